// File: doc/BRIEF.md
# Cascaded Add-Square Stage for GF(2^163)

This block sits directly behind a binary-field multiplier and finishes the arithmetic that would otherwise need extra scheduled cycles. In one registered step it can optionally XOR an addend onto the multiplier product, and then square the result zero, one or two times. With two squarers chained, the fourth power x^4 comes out within the same clock. Because the add and the squarings happen inside that step, a controller issues one operation where it would otherwise issue two or three. This shortens the schedule and saves register-file reads and writes.

Field elements are 163 bits wide and are reduced modulo x^163 + x^7 + x^6 + x^3 + 1. Squaring spreads the input bits into the even positions of a 325-bit value and then reduces that value. A feedback select makes the stage take its own registered result as the operand in place of the product. Holding that select for n back-to-back fourth-power steps yields x^(4^n), which is the repeated raising step of an inversion chain. The stage accepts a new operation every cycle, and each result appears one cycle after it is issued.

Top module: `gf_addsq_unit`

## Requirements
- R1: While `rst` is high, `out_valid` is 0 and `result` is all zeros.
- R2: Mode 0 (pass) gives `result` equal to the operand.
- R3: Mode 1 (add) gives `result` equal to operand XOR `addend`.
- R4: Mode 2 (square) gives `result` equal to operand squared, reduced modulo x^163 + x^7 + x^6 + x^3 + 1.
- R5: Mode 3 (add then square) gives `result` equal to (operand XOR `addend`)^2.
- R6: Mode 4 (double square) gives `result` equal to operand^4, finished in a single clock.
- R7: Mode 5 (add then double square) gives `result` equal to (operand XOR `addend`)^4.
- R8: Mode codes 6 and 7 behave as pass. In these modes `addend` has no effect on `result`.
- R9: When `in_valid` is sampled high at a rising edge, that operation's result and `out_valid`=1 appear at that same edge. This holds when operations are issued on back-to-back cycles.
- R10: When `in_valid` is sampled low, `out_valid` goes to 0 and `result` keeps its value, whatever the other inputs are.
- R11: When `fb_sel` is 1, the operand is the current `result` and `product` is ignored. n consecutive mode-4 steps with `fb_sel`=1 turn x into x^(4^n).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is issued this cycle |
| mode | input | 3 | Operation select: 0 pass, 1 add, 2 square, 3 add-square, 4 double square, 5 add-double square, 6 and 7 pass |
| fb_sel | input | 1 | 1 selects the registered result as the operand instead of `product` |
| product | input | 163 | Field element from the multiplier |
| addend | input | 163 | Field element XORed in by the add modes |
| out_valid | output | 1 | `result` was written by the operation of the previous cycle |
| result | output | 163 | Registered field element |

## Verification
A wrong reduction tap or a misplaced spread bit in a squarer corrupts `result` on the first square-mode operation whose product reaches the high half of the 325-bit value. The bench therefore drives the top bit and all-ones operands, and the error shows on the very next cycle. A decode fault shows up the cycle after the affected mode is issued, as a missing or extra XOR or as the wrong power. A fault in the feedback mux or in the hold path corrupts every later chained fourth power, so it is seen as soon as a chain runs or the stage sits idle for one cycle.

// File: rtl/gf_pp_pkg.sv
package gf_pp_pkg;
  localparam int FIELD_W = 163;
  localparam logic [FIELD_W-1:0] FIELD_POLY_LOW = FIELD_W'(8'hC9);
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    PP_PASS    = 3'd0,
    PP_ADD     = 3'd1,
    PP_SQ      = 3'd2,
    PP_ADD_SQ  = 3'd3,
    PP_SQ2     = 3'd4,
    PP_ADD_SQ2 = 3'd5
  } pp_mode_e;
endpackage

// File: rtl/gf_pp_decode.sv
module gf_pp_decode
  import gf_pp_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [MODE_W-1:0] mode,
  output logic              add_en,
  output logic [CNT_W-1:0]  sq_cnt
);
  always_comb begin
    add_en = 1'b0;
    sq_cnt = '0;
    case (mode)
      PP_ADD:     begin add_en = 1'b1; end
      PP_SQ:      begin sq_cnt = CNT_W'(1); end
      PP_ADD_SQ:  begin add_en = 1'b1; sq_cnt = CNT_W'(1); end
      PP_SQ2:     begin sq_cnt = CNT_W'(2); end
      PP_ADD_SQ2: begin add_en = 1'b1; sq_cnt = CNT_W'(2); end
      default:    begin add_en = 1'b0; sq_cnt = '0; end
    endcase
  end
endmodule

// File: rtl/gf_sqr.sv
module gf_sqr #(
  parameter int             FW       = 163,
  parameter logic [FW-1:0]  POLY_LOW = FW'(8'hC9)
) (
  input  logic [FW-1:0] a,
  output logic [FW-1:0] y
);
  localparam int WIDE_W = 2*FW - 1;

  logic [WIDE_W-1:0] spread;
  logic [WIDE_W-1:0] work;

  // interleave zeros: bit i of a lands on bit 2i
  always_comb begin
    spread = '0;
    for (int i = 0; i < FW; i++) spread[2*i] = a[i];
  end

  // fold high terms down, top bit first
  always_comb begin
    work = spread;
    for (int i = WIDE_W - 1; i >= FW; i--) begin
      if (work[i]) work[i -: FW+1] = work[i -: FW+1] ^ {1'b1, POLY_LOW};
    end
  end

  assign y = work[FW-1:0];
endmodule

// File: rtl/gf_sq_cascade.sv
module gf_sq_cascade #(
  parameter int             FW       = 163,
  parameter logic [FW-1:0]  POLY_LOW = FW'(8'hC9),
  parameter int             STAGES   = 2,
  parameter int             CNT_W    = $clog2(STAGES + 1)
) (
  input  logic [FW-1:0]    din,
  input  logic [CNT_W-1:0] sel,
  output logic [FW-1:0]    dout
);
  logic [FW-1:0] tap [STAGES+1];

  assign tap[0] = din;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    gf_sqr #(.FW(FW), .POLY_LOW(POLY_LOW)) u_sqr (
      .a (tap[g]),
      .y (tap[g+1])
    );
  end

  always_comb begin
    dout = din;
    for (int k = 0; k <= STAGES; k++) begin
      if (sel == CNT_W'(k)) dout = tap[k];
    end
  end
endmodule

// File: rtl/gf_addsq_unit.sv
module gf_addsq_unit
  import gf_pp_pkg::*;
#(
  parameter int             FW       = FIELD_W,
  parameter logic [FW-1:0]  POLY_LOW = FIELD_POLY_LOW,
  parameter int             SQ_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [MODE_W-1:0] mode,
  input  logic              fb_sel,
  input  logic [FW-1:0]     product,
  input  logic [FW-1:0]     addend,
  output logic              out_valid,
  output logic [FW-1:0]     result
);
  localparam int CNT_W = $clog2(SQ_DEPTH + 1);

  logic             add_en;
  logic [CNT_W-1:0] sq_cnt;
  logic [FW-1:0]    operand;
  logic [FW-1:0]    summed;
  logic [FW-1:0]    powered;

  gf_pp_decode #(.CNT_W(CNT_W)) u_dec (
    .mode   (mode),
    .add_en (add_en),
    .sq_cnt (sq_cnt)
  );

  assign operand = fb_sel ? result : product;
  assign summed  = add_en ? (operand ^ addend) : operand;

  gf_sq_cascade #(
    .FW(FW), .POLY_LOW(POLY_LOW), .STAGES(SQ_DEPTH), .CNT_W(CNT_W)
  ) u_sq (
    .din  (summed),
    .sel  (sq_cnt),
    .dout (powered)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= powered;
    end
  end
endmodule

// File: rtl/gf_addsq_chk.sv
module gf_addsq_chk #(
  parameter int FW = 163
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    mode,
  input logic          fb_sel,
  input logic [FW-1:0] product,
  input logic [FW-1:0] addend,
  input logic          out_valid,
  input logic [FW-1:0] result
);
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  // R2
  pass_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !fb_sel && mode == 3'd0) |=> (result == $past(product)));

  // R3
  add_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !fb_sel && mode == 3'd1) |=> (result == ($past(product) ^ $past(addend))));

  // R8
  spare_code_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !fb_sel && mode[2:1] == 2'b11) |=> (result == $past(product)));

  // R11
  fb_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fb_sel && mode == 3'd0) |=> $stable(result));
endmodule

bind gf_addsq_unit gf_addsq_chk #(.FW(FW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mode      (mode),
  .fb_sel    (fb_sel),
  .product   (product),
  .addend    (addend),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/gf_addsq_unit_tb.sv
`timescale 1ns/1ps
module gf_addsq_unit_tb;
  localparam int FW = 163;
  localparam logic [FW-1:0] PLOW = FW'(8'hC9);
  localparam int NV = 14;

  // vector table: mode, product pattern index, addend pattern index
  localparam int TMODE [NV] = '{0, 1, 2, 2, 2, 3, 3, 4, 4, 5, 5, 6, 7, 1};
  localparam int TPROD [NV] = '{3, 4, 0, 1, 2, 3, 1, 1, 5, 2, 4, 5, 3, 2};
  localparam int TADD  [NV] = '{2, 5, 3, 4, 5, 1, 2, 3, 0, 1, 3, 2, 4, 2};

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [2:0]    mode;
  logic          fb_sel;
  logic [FW-1:0] product;
  logic [FW-1:0] addend;
  logic          out_valid;
  logic [FW-1:0] result;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  gf_addsq_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .fb_sel(fb_sel),
    .product(product), .addend(addend), .out_valid(out_valid), .result(result)
  );

  function automatic logic [FW-1:0] pat(int k);
    case (k)
      0:       pat = FW'(1);
      1:       pat = {1'b1, {(FW-1){1'b0}}};
      2:       pat = {FW{1'b1}};
      3:       pat = {3'b101, {20{8'hA5}}};
      4:       pat = {3'b011, {10{16'h1234}}};
      default: pat = {3'b110, {5{32'hDEADBEEF}}};
    endcase
  endfunction

  // bit-serial multiply, MSB first
  function automatic logic [FW-1:0] ref_mul(logic [FW-1:0] a, logic [FW-1:0] b);
    logic [FW-1:0] r = '0;
    for (int i = FW - 1; i >= 0; i--) begin
      logic top = r[FW-1];
      r = r << 1;
      if (top) r = r ^ PLOW;
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [FW-1:0] ref_op(int m, logic [FW-1:0] p, logic [FW-1:0] a);
    logic [FW-1:0] v = p;
    int sq = 0;
    if (m == 1 || m == 3 || m == 5) v = p ^ a;
    if (m == 2 || m == 3) sq = 1;
    if (m == 4 || m == 5) sq = 2;
    for (int s = 0; s < sq; s++) v = ref_mul(v, v);
    return v;
  endfunction

  function automatic string req_of(int m);
    case (m)
      0: req_of = "R2";
      1: req_of = "R3";
      2: req_of = "R4";
      3: req_of = "R5";
      4: req_of = "R6";
      5: req_of = "R7";
      default: req_of = "R8";
    endcase
  endfunction

  task automatic chk(string req, logic [FW-1:0] act, logic [FW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(int m, logic f, logic [FW-1:0] p, logic [FW-1:0] a);
    in_valid = 1'b1;
    mode     = 3'(m);
    fb_sel   = f;
    product  = p;
    addend   = a;
  endtask

  task automatic idle();
    in_valid = 1'b0;
    fb_sel   = 1'b0;
  endtask

  initial begin
    logic [FW-1:0] x;
    logic [FW-1:0] e1;
    logic [FW-1:0] held;
    rst = 1'b1; in_valid = 1'b0; mode = '0; fb_sel = 1'b0;
    product = pat(2); addend = pat(5);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", FW'(out_valid), FW'(0));
    chk("R1 result", result, '0);
    in_valid = 1'b1;
    @(negedge clk);
    chk("R1 valid during reset", FW'(out_valid), FW'(0));
    chk("R1 result during reset", result, '0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      issue(TMODE[v], 1'b0, pat(TPROD[v]), pat(TADD[v]));
      @(negedge clk);
      idle();
      chk(req_of(TMODE[v]), result, ref_op(TMODE[v], pat(TPROD[v]), pat(TADD[v])));
      chk("R9 out_valid", FW'(out_valid), FW'(1));
    end

    // R8: spare codes with two addends give the same result
    issue(6, 1'b0, pat(4), pat(0));
    @(negedge clk);
    issue(6, 1'b0, pat(4), pat(2));
    chk("R8 code6 addend A", result, pat(4));
    @(negedge clk);
    idle();
    chk("R8 code6 addend B", result, pat(4));

    // R9: back-to-back issue
    e1 = ref_op(3, pat(5), pat(4));
    issue(3, 1'b0, pat(5), pat(4));
    @(negedge clk);
    issue(4, 1'b0, pat(3), pat(0));
    chk("R9 first of pair", result, e1);
    @(negedge clk);
    idle();
    chk("R9 second of pair", result, ref_op(4, pat(3), pat(0)));
    chk("R9 valid second", FW'(out_valid), FW'(1));

    // R10: idle with changing inputs
    held = result;
    mode = 3'd5; product = pat(1); addend = pat(2);
    @(negedge clk);
    chk("R10 valid low", FW'(out_valid), FW'(0));
    chk("R10 held", result, held);
    mode = 3'd2; product = pat(0);
    @(negedge clk);
    chk("R10 held again", result, held);

    // R11: feedback chain of x^4 steps
    x = pat(4);
    issue(0, 1'b0, x, pat(5));
    @(negedge clk);
    chk("R11 load", result, x);
    for (int n = 1; n <= 3; n++) begin
      issue(4, 1'b1, pat(2), pat(5));
      @(negedge clk);
      x = ref_op(4, x, '0);
      chk($sformatf("R11 step %0d", n), result, x);
    end
    // R11: feedback with add-square uses result, not product
    issue(3, 1'b1, pat(1), pat(3));
    @(negedge clk);
    idle();
    x = ref_op(3, x, pat(3));
    chk("R11 fb add-square", result, x);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule